// File: doc/BRIEF.md
# UART Receive Queue with Occupancy Flags

This block sits between a UART deserializer and the register interface of a serial port. Every character the deserializer completes is stored as a 12-bit entry: the data byte in bits [7:0] and four error flags in bits [11:8]. A line break is stored as an entry of its own. A mode input switches the queue at run time between a 16-entry first-in first-out buffer and a single holding register. Whenever the mode changes, the queue is emptied.

The register interface takes the oldest entry with a read strobe. The entry is shown combinationally on `rd_entry` in the cycle the strobe is high. On the strobe's clock edge the queue advances, and the entry's four error bits are copied into a receive-status register, which software can clear. The block drives full and empty flags, a receive-level event for the interrupt logic, and a one-cycle overrun pulse when a character is lost.

A three-state machine tracks occupancy. **EMPTY** goes to **PART** on an accepted push in queue mode. EMPTY goes to **FULL** on an accepted push in holding mode. PART goes to FULL when a push without a pop fills the last slot. PART goes to EMPTY when a pop without a push takes the last entry. FULL goes to PART on a pop in queue mode. FULL goes to EMPTY on a pop in holding mode. From any state, a mode change forces EMPTY.

Top module: `rxq_top`

## Requirements
- R1: After reset, `rx_empty`=1, `rx_full`=0, `rx_stat`=0, `lvl_evt`=0 and `ovr_pulse`=0.
- R2: With `fifo_en`=1, the queue holds up to 16 entries and returns them in arrival order. `rx_full` is 1 exactly when 16 entries are held, and `rx_empty` is 1 exactly when none are held.
- R3: With `fifo_en`=0, one entry is held. `rx_full` rises after the first accepted push, and later pushes are not stored.
- R4: A clock edge where `fifo_en` differs from its value at the previous edge empties the queue and resets the read position to slot 0. A push in that cycle is discarded without an overrun pulse.
- R5: `rd_entry` presents the oldest entry as {error[3:0], data[7:0]}, taking the errors from `push_err`. A read strobe removes that entry and clears `rx_full`.
- R6: A read strobe while empty changes neither occupancy nor read position. `rd_entry` then shows the slot at the current read position.
- R7: On every read strobe, `rx_stat` loads bits [11:8] of the entry presented. `stat_clr` clears `rx_stat` to 0, but a read in the same cycle takes priority.
- R8: `brk_det` pushes the entry 0x400 (error bit 10 set, data zero). It takes priority over a character push in the same cycle, which is then discarded.
- R9: `lvl_evt` rises when occupancy reaches the trigger level (1). It falls when a read drops occupancy to one below that level, or when the queue is emptied by a mode change.
- R10: A push or break that arrives while `rx_full` is 1 is dropped and leaves the stored entries unchanged. `ovr_pulse` is high for exactly the next cycle.
- R11: A push and a read in the same cycle, while neither full nor empty, both take effect, and occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| push_valid | input | 1 | Deserializer has a character this cycle |
| push_data | input | 8 | Received data byte |
| push_err | input | 4 | Error flags stored in entry bits [11:8] |
| brk_det | input | 1 | Break detected; stores 0x400 |
| rd_stb | input | 1 | Data-register read strobe |
| stat_clr | input | 1 | Write to receive-status register (clears it) |
| rd_entry | output | 12 | Oldest entry {err, data} |
| rx_stat | output | 4 | Receive-status register |
| rx_full | output | 1 | Queue full for the current mode |
| rx_empty | output | 1 | Queue empty |
| lvl_evt | output | 1 | Receive-level event |
| ovr_pulse | output | 1 | One-cycle pulse for a dropped push |

## Verification
The assertions check the following on every cycle:
- occupancy never exceeds the capacity of the current mode;
- the state register agrees with the occupancy count;
- a mode change always leaves the queue empty;
- a dropped push or an empty read leaves occupancy unchanged;
- the status register follows reads and clears;
- the level event mirrors non-empty occupancy.

Only the bench's scenarios can show the data itself: that entries come back in arrival order across the pointer wrap, that a break becomes 0x400, and that an empty read returns the stale slot after a flush.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
    localparam int DATA_W  = 8;
    localparam int ERR_W   = 4;
    localparam int ENTRY_W = DATA_W + ERR_W;
    // position of the break flag inside the error field (entry bit 10)
    localparam int BRK_POS = 2;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;

    function automatic logic [ENTRY_W-1:0] brk_entry();
        logic [ERR_W-1:0] e;
        e = '0;
        e[BRK_POS] = 1'b1;
        return {e, {DATA_W{1'b0}}};
    endfunction
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 12,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [W-1:0]  wr_val,
    input  logic [PW-1:0] rd_idx,
    output logic [W-1:0]  rd_val
);
    logic [W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && (wr_idx == PW'(g)))
                slot_q[g] <= wr_val;
        end
    end

    assign rd_val = slot_q[rd_idx];
endmodule

// File: rtl/rxq_ctrl.sv
`timescale 1ns/1ps
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          push_valid,
    input  logic          brk_det,
    input  logic          rd_stb,
    output logic          wr_en,
    output logic          wr_brk,
    output logic [PW-1:0] wr_idx,
    output logic [PW-1:0] rd_idx,
    output logic          do_push,
    output logic          do_pop,
    output logic          flush,
    output logic [CW-1:0] cnt_nx,
    output logic          rx_full,
    output logic          rx_empty,
    output logic          ovr_pulse
);
    occ_e          state_q, state_nx;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] rptr_q, rptr_nx;
    logic          mode_q;
    logic          ovr_q;
    logic          want;
    logic          drop;
    logic [CW-1:0] cap;

    assign flush = (fifo_en != mode_q);
    assign cap   = mode_q ? CW'(DEPTH) : CW'(1);
    assign want  = push_valid | brk_det;

    assign do_push = want && !flush && (state_q != OCC_FULL);
    assign do_pop  = rd_stb && !flush && (state_q != OCC_EMPTY);
    assign drop    = want && !flush && (state_q == OCC_FULL);

    assign cnt_nx  = flush ? '0 : (cnt_q + CW'(do_push) - CW'(do_pop));
    assign rptr_nx = flush ? '0 : (do_pop ? rptr_q + PW'(1) : rptr_q);

    assign wr_en  = do_push;
    assign wr_brk = brk_det;
    assign wr_idx = rptr_q + cnt_q[PW-1:0];
    assign rd_idx = rptr_q;

    // next-state logic
    always_comb begin
        state_nx = state_q;
        if (flush) begin
            state_nx = OCC_EMPTY;
        end else begin
            unique case (state_q)
                OCC_EMPTY: begin
                    if (do_push)
                        state_nx = (cap == CW'(1)) ? OCC_FULL : OCC_PART;
                end
                OCC_PART: begin
                    if (do_push && !do_pop && (cnt_q == cap - CW'(1)))
                        state_nx = OCC_FULL;
                    else if (do_pop && !do_push && (cnt_q == CW'(1)))
                        state_nx = OCC_EMPTY;
                end
                OCC_FULL: begin
                    if (do_pop)
                        state_nx = (cap == CW'(1)) ? OCC_EMPTY : OCC_PART;
                end
                default: state_nx = OCC_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
            rptr_q  <= '0;
            mode_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
            rptr_q  <= rptr_nx;
            mode_q  <= fifo_en;
            ovr_q   <= drop;
        end
    end

    // outputs from state
    always_comb begin
        rx_full   = 1'b0;
        rx_empty  = 1'b0;
        unique case (state_q)
            OCC_EMPTY: rx_empty = 1'b1;
            OCC_PART:  ;
            OCC_FULL:  rx_full  = 1'b1;
            default:   rx_empty = 1'b1;
        endcase
        ovr_pulse = ovr_q;
    end

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cap);                                               // R3
    AST_EMPTY_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty == (cnt_q == '0));                                  // R2
    AST_FULL_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full == (cnt_q == cap));                                  // R2
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rx_empty && rptr_q == '0));                       // R4
    AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && want && !rd_stb && !flush) |=> (rx_full && $stable(cnt_q))); // R10
    AST_RD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && rd_stb && !want && !flush) |=> (rx_empty && $stable(rptr_q))); // R6
    AST_SIMUL: assert property (@(posedge clk) disable iff (!rst_n)
        (want && rd_stb && !rx_full && !rx_empty && !flush) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/rxq_status.sv
`timescale 1ns/1ps
module rxq_status
    import rxq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int LEVEL_TRIG = 1,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic             stat_clr,
    input  logic [ERR_W-1:0] head_err,
    input  logic             do_push,
    input  logic             do_pop,
    input  logic             flush,
    input  logic [CW-1:0]    cnt_nx,
    output logic [ERR_W-1:0] rx_stat,
    output logic             lvl_evt
);
    logic [ERR_W-1:0] stat_q;
    logic             lvl_q, lvl_nx;

    always_comb begin
        lvl_nx = lvl_q;
        if (flush)
            lvl_nx = 1'b0;
        else if (do_push && !do_pop && (cnt_nx == CW'(LEVEL_TRIG)))
            lvl_nx = 1'b1;
        else if (do_pop && !do_push && (cnt_nx == CW'(LEVEL_TRIG - 1)))
            lvl_nx = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            lvl_q  <= 1'b0;
        end else begin
            lvl_q <= lvl_nx;
            if (rd_stb)
                stat_q <= head_err;
            else if (stat_clr)
                stat_q <= '0;
        end
    end

    assign rx_stat = stat_q;
    assign lvl_evt = lvl_q;

    AST_STAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rx_stat == $past(head_err)));                    // R7
    AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !rd_stb) |=> (rx_stat == '0));                  // R7
    AST_LVL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lvl_evt);                                         // R9
endmodule

// File: rtl/rxq_top.sv
`timescale 1ns/1ps
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int LEVEL_TRIG = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_en,
    input  logic        push_valid,
    input  logic [7:0]  push_data,
    input  logic [3:0]  push_err,
    input  logic        brk_det,
    input  logic        rd_stb,
    input  logic        stat_clr,
    output logic [11:0] rd_entry,
    output logic [3:0]  rx_stat,
    output logic        rx_full,
    output logic        rx_empty,
    output logic        lvl_evt,
    output logic        ovr_pulse
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic               wr_en, wr_brk, do_push, do_pop, flush;
    logic [PW-1:0]      wr_idx, rd_idx;
    logic [CW-1:0]      cnt_nx;
    logic [ENTRY_W-1:0] wr_val, head;

    assign wr_val = wr_brk ? brk_entry() : {push_err, push_data};

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .push_valid (push_valid),
        .brk_det    (brk_det),
        .rd_stb     (rd_stb),
        .wr_en      (wr_en),
        .wr_brk     (wr_brk),
        .wr_idx     (wr_idx),
        .rd_idx     (rd_idx),
        .do_push    (do_push),
        .do_pop     (do_pop),
        .flush      (flush),
        .cnt_nx     (cnt_nx),
        .rx_full    (rx_full),
        .rx_empty   (rx_empty),
        .ovr_pulse  (ovr_pulse)
    );

    rxq_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_val (wr_val),
        .rd_idx (rd_idx),
        .rd_val (head)
    );

    rxq_status #(.DEPTH(DEPTH), .LEVEL_TRIG(LEVEL_TRIG)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .stat_clr (stat_clr),
        .head_err (head[ENTRY_W-1:DATA_W]),
        .do_push  (do_push),
        .do_pop   (do_pop),
        .flush    (flush),
        .cnt_nx   (cnt_nx),
        .rx_stat  (rx_stat),
        .lvl_evt  (lvl_evt)
    );

    assign rd_entry = head;

    if (LEVEL_TRIG == 1) begin : g_lvl_chk
        AST_LVL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_evt == !rx_empty);                                   // R9
    end
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_full && rx_empty));                                     // R2
endmodule

// File: tb/sim_rxq_top.sv
`timescale 1ns/1ps
module sim_rxq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0, push_valid = 1'b0, brk_det = 1'b0;
    logic        rd_stb = 1'b0, stat_clr = 1'b0;
    logic [7:0]  push_data = '0;
    logic [3:0]  push_err = '0;
    logic [11:0] rd_entry;
    logic [3:0]  rx_stat;
    logic        rx_full, rx_empty, lvl_evt, ovr_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rxq_top u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_valid(push_valid),
        .push_data(push_data), .push_err(push_err), .brk_det(brk_det),
        .rd_stb(rd_stb), .stat_clr(stat_clr), .rd_entry(rd_entry),
        .rx_stat(rx_stat), .rx_full(rx_full), .rx_empty(rx_empty),
        .lvl_evt(lvl_evt), .ovr_pulse(ovr_pulse)
    );

    typedef struct packed {
        logic        en, push, brk, rd, clr;
        logic [7:0]  din;
        logic [3:0]  err;
        logic [11:0] exp_rd;
        logic        exp_empty, exp_full;
        logic [3:0]  exp_stat;
        logic        exp_lvl, exp_ovr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'hA5,4'h0,12'h000,1'b0,1'b1,4'h0,1'b1,1'b0}, // R3 single accept
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h3C,4'h0,12'h000,1'b0,1'b1,4'h0,1'b1,1'b1}, // R10 drop
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,4'h0,12'h0A5,1'b1,1'b0,4'h0,1'b0,1'b0}, // R5 R9 read
        '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h77,4'h0,12'h000,1'b1,1'b0,4'h0,1'b0,1'b0}, // R4 toggle
        '{1'b1,1'b0,1'b0,1'b1,1'b0,8'h00,4'h0,12'h0A5,1'b1,1'b0,4'h0,1'b0,1'b0}, // R6 empty read
        '{1'b1,1'b1,1'b0,1'b0,1'b0,8'h11,4'h3,12'h000,1'b0,1'b0,4'h0,1'b1,1'b0}, // R9 rise
        '{1'b1,1'b1,1'b1,1'b0,1'b0,8'h22,4'h0,12'h000,1'b0,1'b0,4'h0,1'b1,1'b0}, // R8 break
        '{1'b1,1'b1,1'b0,1'b1,1'b0,8'h33,4'h0,12'h311,1'b0,1'b0,4'h3,1'b1,1'b0}, // R11 R7
        '{1'b1,1'b0,1'b0,1'b1,1'b1,8'h00,4'h0,12'h400,1'b0,1'b0,4'h4,1'b1,1'b0}, // R8 R7
        '{1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,4'h0,12'h000,1'b0,1'b0,4'h0,1'b1,1'b0}, // R7 clear
        '{1'b1,1'b0,1'b0,1'b1,1'b0,8'h00,4'h0,12'h033,1'b1,1'b0,4'h0,1'b0,1'b0}, // R9 fall
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'h0,12'h000,1'b1,1'b0,4'h0,1'b0,1'b0}  // R4 toggle
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic en, push, brk, rd, clr,
                         input logic [7:0] d, input logic [3:0] e);
        fifo_en = en; push_valid = push; brk_det = brk;
        rd_stb = rd; stat_clr = clr; push_data = d; push_err = e;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        drive(fifo_en, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'h0);
    endtask

    task automatic chk_idle(input string req, input logic emp, ful, lvl, ovr);
        chk({req, " empty"}, 32'(rx_empty), 32'(emp));
        chk({req, " full"}, 32'(rx_full), 32'(ful));
        chk({req, " lvl"}, 32'(lvl_evt), 32'(lvl));
        chk({req, " ovr"}, 32'(ovr_pulse), 32'(ovr));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_idle("R1", 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R1 stat", 32'(rx_stat), 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].en, TBL[i].push, TBL[i].brk, TBL[i].rd, TBL[i].clr,
                  TBL[i].din, TBL[i].err);
            #1;
            if (TBL[i].rd)
                chk($sformatf("R5 row%0d rd_entry", i), 32'(rd_entry), 32'(TBL[i].exp_rd));
            step();
            chk_idle($sformatf("R2 row%0d", i), TBL[i].exp_empty, TBL[i].exp_full,
                     TBL[i].exp_lvl, TBL[i].exp_ovr);
            chk($sformatf("R7 row%0d stat", i), 32'(rx_stat), 32'(TBL[i].exp_stat));
        end

        // R2 fill queue mode (toggle to queue mode first)
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'h0);
        step();
        for (int i = 0; i < 16; i++) begin
            drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'(8'h40 + i), 4'(i));
            step();
            chk($sformatf("R2 full after %0d", i + 1), 32'(rx_full), 32'(i == 15));
            chk("R2 not empty", 32'(rx_empty), 32'h0);
        end
        // R10 push and read while full: push dropped, read occurs
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hEE, 4'hF);
        #1;
        chk("R5 head", 32'(rd_entry), 32'h040);
        step();
        chk("R10 ovr pulse", 32'(ovr_pulse), 32'h1);
        chk("R5 full cleared", 32'(rx_full), 32'h0);
        step();
        chk("R10 ovr one cycle", 32'(ovr_pulse), 32'h0);
        // R2 order across the rest
        for (int i = 1; i < 16; i++) begin
            drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'h0);
            #1;
            chk($sformatf("R2 order %0d", i), 32'(rd_entry), 32'({4'(i), 8'(8'h40 + i)}));
            step();
        end
        chk_idle("R9 drained", 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7 last stat", 32'(rx_stat), 32'hF);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 4'h0);
        step();
        chk("R7 clear", 32'(rx_stat), 32'h0);

        // R4 flush with entries present clears level event
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'(i), 4'h0);
            step();
        end
        chk("R9 level held", 32'(lvl_evt), 32'h1);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'h0);
        step();
        chk_idle("R4 flush", 1'b1, 1'b0, 1'b0, 1'b0);

        // R8 break into holding mode, then a second break overruns
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'h0);
        step();
        chk("R8 full", 32'(rx_full), 32'h1);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'h0);
        step();
        chk("R10 brk ovr", 32'(ovr_pulse), 32'h1);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'h0);
        #1;
        chk("R8 entry", 32'(rd_entry), 32'h400);
        step();
        chk("R8 stat", 32'(rx_stat), 32'h4);

        // R1 reset again with data held
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 4'h0);
        step();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 rereset", 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R1 stat", 32'(rx_stat), 32'h0);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end
endmodule